// File: doc/BRIEF.md
# Integer Execute Stage with Condition Field

This block is the integer execute stage of a 32-bit load/store processor pipeline. Each cycle it may accept one decoded operation. The operation carries an operation code, two register operands, a 16-bit immediate, and a flag saying that the base register index is zero. One clock edge later the block presents a registered 32-bit result and, for operations that set it, a registered 4-bit condition field.

The stage covers several groups of operations. The arithmetic group is add, add-immediate in low and high forms, add of the incoming carry flag, subtract-from and multiply-low. The logical group is and, and-complement, or, or-complement, xor, nand, nor and equivalence, with low and high immediate forms where they exist. It also covers left and right shifts, sign extension of a byte or halfword, and signed and unsigned compares. The three record-form AND operations also compare their result against zero.

Subtract-from and arithmetic right shift both clear the architectural carry flag, which is held outside the block. Any operation code outside the supported set raises an illegal-operation pulse and changes neither the result nor the condition field.

Top module: `int_exec_unit`

## Requirements
- R1: While reset is high, and on the first edge after it, result and cond are 0 and res_valid, cond_valid, illegal and carry_clr are 0.
- R2: An accepted legal operation that writes a register updates result on the next clock edge and pulses res_valid for exactly that cycle. Compares do not write a register: they leave result unchanged and keep res_valid low.
- R3: Add forms: ADD gives a+b. ADDI gives base+zext(imm). ADDIS gives base+(imm<<16). For ADDI and ADDIS only, base is 0 when base_zero is high.
- R4: Logical forms give AND, AND with ~b, OR, OR with ~b, XOR, NAND, NOR and XNOR of the operands. The immediate forms use zext(imm) in the low form and imm<<16 in the high form.
- R5: The record AND forms (register, low immediate, high immediate) also compare their result as signed against 0. They write cond bit0 = result<0, bit1 = result>0, bit2 = result==0, and bit3 = 0, and they pulse cond_valid.
- R6: Compares write cond with bit0 = a<b, bit1 = b<a, bit2 = a==b and bit3 = 0. The signed compares use two's-complement order and the unsigned compares use magnitude order. The second operand is either register b or zext(imm).
- R7: SLW, SRW and SRAW take the shift amount from b[5:0], and SRAWI takes it from imm[5:0]. Amounts from 32 to 63 give 0 for the logical shifts and 32 copies of a[31] for the arithmetic shift.
- R8: SUBF gives b-a and SUBFIC gives zext(imm)-a. These two, together with SRAW and SRAWI, pulse carry_clr alongside res_valid. No other operation pulses carry_clr.
- R9: ADDZE gives a plus carry_in, where carry_in counts as 0 or 1.
- R10: EXTSB sign-extends a[7:0] and EXTSH sign-extends a[15:0] to 32 bits.
- R11: MULLW gives the low 32 bits of a*b, and MULLI gives the low 32 bits of a*zext(imm).
- R12: Operation codes 32 to 63 are illegal. Such a code pulses illegal for one cycle, keeps res_valid, cond_valid and carry_clr low, and leaves result and cond unchanged.
- R13: When op_valid is low, the next cycle has no pulses, and result and cond keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 6 | Decoded operation code |
| opnd_a | input | 32 | First register operand (base) |
| opnd_b | input | 32 | Second register operand |
| imm16 | input | 16 | Immediate constant |
| base_zero | input | 1 | Base register index is zero |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Registered result |
| res_valid | output | 1 | Result written this cycle |
| cond | output | 4 | Registered condition field |
| cond_valid | output | 1 | Condition field written this cycle |
| carry_clr | output | 1 | Carry flag to be cleared |
| illegal | output | 1 | Unsupported operation code seen |

## Verification
Random operands go through every legal code. Immediates and carry values are drawn at random, and base_zero is sometimes set, which separates the low and high immediate forms and the zeroed base from a real register read. Directed cases cover signed and unsigned compares at 0x80000000 against 1, equal operands, and a record AND whose result is zero or negative, so that each condition bit is exercised. Further directed cases use shift amounts of 31, 32 and 63 on a negative value, where the logical and arithmetic behaviour splits. Illegal codes and idle cycles between operations show whether the result and condition registers hold their values.

// File: rtl/exec_pkg.sv
package exec_pkg;

  typedef enum logic [5:0] {
    OP_ADD    = 6'd0,  OP_ADDI   = 6'd1,  OP_ADDIS  = 6'd2,  OP_ADDZE  = 6'd3,
    OP_ANDR   = 6'd4,  OP_ANDC   = 6'd5,  OP_ANDIR  = 6'd6,  OP_ANDISR = 6'd7,
    OP_OR     = 6'd8,  OP_ORC    = 6'd9,  OP_ORI    = 6'd10, OP_ORIS   = 6'd11,
    OP_XOR    = 6'd12, OP_XORI   = 6'd13, OP_XORIS  = 6'd14, OP_NAND   = 6'd15,
    OP_NOR    = 6'd16, OP_EQV    = 6'd17, OP_MULLW  = 6'd18, OP_MULLI  = 6'd19,
    OP_SLW    = 6'd20, OP_SRW    = 6'd21, OP_SRAW   = 6'd22, OP_SRAWI  = 6'd23,
    OP_EXTSB  = 6'd24, OP_EXTSH  = 6'd25, OP_SUBF   = 6'd26, OP_SUBFIC = 6'd27,
    OP_CMPW   = 6'd28, OP_CMPWI  = 6'd29, OP_CMPLW  = 6'd30, OP_CMPLWI = 6'd31
  } op_e;

  typedef enum logic [1:0] {
    SRC_REG, SRC_IMM_LO, SRC_IMM_HI, SRC_CARRY
  } bsrc_e;

  typedef enum logic [3:0] {
    FN_ADD, FN_AND, FN_ANDC, FN_OR, FN_ORC, FN_XOR, FN_NAND, FN_NOR,
    FN_EQV, FN_MUL, FN_SLL, FN_SRL, FN_SRA, FN_EXTB, FN_EXTH, FN_SUBF
  } fn_e;

  // bit0 = less, bit1 = greater, bit2 = equal, bit3 = overflow copy
  typedef struct packed {
    logic so;
    logic eq;
    logic gt;
    logic lt;
  } cond_t;

  typedef struct packed {
    logic  legal;
    bsrc_e bsel;
    logic  base_zeroable;
    fn_e   fn;
    logic  wr_res;
    logic  cmp_ops;    // compare operands directly
    logic  cmp_zero;   // compare result against zero (record form)
    logic  cmp_signed;
    logic  clr_carry;
  } ctrl_t;

endpackage

// File: rtl/exec_decode.sv
module exec_decode
  import exec_pkg::*;
(
  input  logic [5:0] op_code,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{legal: 1'b1, bsel: SRC_REG, base_zeroable: 1'b0, fn: FN_ADD,
             wr_res: 1'b1, cmp_ops: 1'b0, cmp_zero: 1'b0, cmp_signed: 1'b1,
             clr_carry: 1'b0};
    case (op_code)
      OP_ADD:    ctrl.fn = FN_ADD;
      OP_ADDI:   begin ctrl.bsel = SRC_IMM_LO; ctrl.base_zeroable = 1'b1; end
      OP_ADDIS:  begin ctrl.bsel = SRC_IMM_HI; ctrl.base_zeroable = 1'b1; end
      OP_ADDZE:  ctrl.bsel = SRC_CARRY;
      OP_ANDR:   begin ctrl.fn = FN_AND; ctrl.cmp_zero = 1'b1; end
      OP_ANDC:   ctrl.fn = FN_ANDC;
      OP_ANDIR:  begin ctrl.fn = FN_AND; ctrl.bsel = SRC_IMM_LO; ctrl.cmp_zero = 1'b1; end
      OP_ANDISR: begin ctrl.fn = FN_AND; ctrl.bsel = SRC_IMM_HI; ctrl.cmp_zero = 1'b1; end
      OP_OR:     ctrl.fn = FN_OR;
      OP_ORC:    ctrl.fn = FN_ORC;
      OP_ORI:    begin ctrl.fn = FN_OR; ctrl.bsel = SRC_IMM_LO; end
      OP_ORIS:   begin ctrl.fn = FN_OR; ctrl.bsel = SRC_IMM_HI; end
      OP_XOR:    ctrl.fn = FN_XOR;
      OP_XORI:   begin ctrl.fn = FN_XOR; ctrl.bsel = SRC_IMM_LO; end
      OP_XORIS:  begin ctrl.fn = FN_XOR; ctrl.bsel = SRC_IMM_HI; end
      OP_NAND:   ctrl.fn = FN_NAND;
      OP_NOR:    ctrl.fn = FN_NOR;
      OP_EQV:    ctrl.fn = FN_EQV;
      OP_MULLW:  ctrl.fn = FN_MUL;
      OP_MULLI:  begin ctrl.fn = FN_MUL; ctrl.bsel = SRC_IMM_LO; end
      OP_SLW:    ctrl.fn = FN_SLL;
      OP_SRW:    ctrl.fn = FN_SRL;
      OP_SRAW:   begin ctrl.fn = FN_SRA; ctrl.clr_carry = 1'b1; end
      OP_SRAWI:  begin ctrl.fn = FN_SRA; ctrl.bsel = SRC_IMM_LO; ctrl.clr_carry = 1'b1; end
      OP_EXTSB:  ctrl.fn = FN_EXTB;
      OP_EXTSH:  ctrl.fn = FN_EXTH;
      OP_SUBF:   begin ctrl.fn = FN_SUBF; ctrl.clr_carry = 1'b1; end
      OP_SUBFIC: begin ctrl.fn = FN_SUBF; ctrl.bsel = SRC_IMM_LO; ctrl.clr_carry = 1'b1; end
      OP_CMPW:   begin ctrl.wr_res = 1'b0; ctrl.cmp_ops = 1'b1; end
      OP_CMPWI:  begin ctrl.wr_res = 1'b0; ctrl.cmp_ops = 1'b1; ctrl.bsel = SRC_IMM_LO; end
      OP_CMPLW:  begin ctrl.wr_res = 1'b0; ctrl.cmp_ops = 1'b1; ctrl.cmp_signed = 1'b0; end
      OP_CMPLWI: begin
        ctrl.wr_res = 1'b0; ctrl.cmp_ops = 1'b1; ctrl.cmp_signed = 1'b0;
        ctrl.bsel = SRC_IMM_LO;
      end
      default: begin ctrl.legal = 1'b0; ctrl.wr_res = 1'b0; end
    endcase
  end
endmodule

// File: rtl/exec_operand.sv
module exec_operand
  import exec_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IMMW = 16
) (
  input  bsrc_e             bsel,
  input  logic              base_zeroable,
  input  logic              base_zero,
  input  logic [XLEN-1:0]   reg_a,
  input  logic [XLEN-1:0]   reg_b,
  input  logic [IMMW-1:0]   imm,
  input  logic              carry_in,
  output logic [XLEN-1:0]   src_a,
  output logic [XLEN-1:0]   src_b
);
  localparam int PADW = XLEN - IMMW;

  logic [XLEN-1:0] imm_lo, imm_hi;
  assign imm_lo = {{PADW{1'b0}}, imm};
  assign imm_hi = {imm, {PADW{1'b0}}};

  assign src_a = (base_zeroable && base_zero) ? '0 : reg_a;

  always_comb begin
    case (bsel)
      SRC_IMM_LO: src_b = imm_lo;
      SRC_IMM_HI: src_b = imm_hi;
      SRC_CARRY:  src_b = {{(XLEN-1){1'b0}}, carry_in};
      default:    src_b = reg_b;
    endcase
  end
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  fn_e             fn,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  localparam int SHW = $clog2(XLEN) + 1;

  logic [SHW-1:0]  amt;
  logic            amt_big;
  logic [XLEN-1:0] sll_v, srl_v, sra_v, prod;

  assign amt     = b[SHW-1:0];
  assign amt_big = amt[SHW-1];
  assign sll_v   = amt_big ? '0 : (a << amt[SHW-2:0]);
  assign srl_v   = amt_big ? '0 : (a >> amt[SHW-2:0]);
  assign sra_v   = amt_big ? {XLEN{a[XLEN-1]}} : XLEN'($signed(a) >>> amt[SHW-2:0]);
  assign prod    = a * b;

  always_comb begin
    case (fn)
      FN_ADD:  y = a + b;
      FN_AND:  y = a & b;
      FN_ANDC: y = a & ~b;
      FN_OR:   y = a | b;
      FN_ORC:  y = a | ~b;
      FN_XOR:  y = a ^ b;
      FN_NAND: y = ~(a & b);
      FN_NOR:  y = ~(a | b);
      FN_EQV:  y = ~(a ^ b);
      FN_MUL:  y = prod;
      FN_SLL:  y = sll_v;
      FN_SRL:  y = srl_v;
      FN_SRA:  y = sra_v;
      FN_EXTB: y = {{(XLEN-8){a[7]}}, a[7:0]};
      FN_EXTH: y = {{(XLEN-16){a[15]}}, a[15:0]};
      default: y = b - a;
    endcase
  end
endmodule

// File: rtl/exec_cmp.sv
module exec_cmp
  import exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            signed_mode,
  input  logic [XLEN-1:0] x,
  input  logic [XLEN-1:0] y,
  output cond_t           c
);
  logic [XLEN:0] xe, ye;
  // widen by one bit: sign copy for signed order, zero for magnitude order
  assign xe = {signed_mode & x[XLEN-1], x};
  assign ye = {signed_mode & y[XLEN-1], y};

  always_comb begin
    c.lt = $signed(xe) < $signed(ye);
    c.gt = $signed(ye) < $signed(xe);
    c.eq = (x == y);
    c.so = 1'b0;
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import exec_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IMMW = 16,
  parameter int OPW  = 6,
  parameter int CW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [OPW-1:0]  op_code,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  input  logic [IMMW-1:0] imm16,
  input  logic            base_zero,
  input  logic            carry_in,
  output logic [XLEN-1:0] result,
  output logic            res_valid,
  output logic [CW-1:0]   cond,
  output logic            cond_valid,
  output logic            carry_clr,
  output logic            illegal
);
  ctrl_t           ctrl;
  logic [XLEN-1:0] src_a, src_b, alu_y;
  logic [XLEN-1:0] cmp_x, cmp_y;
  cond_t           cmp_c;

  exec_decode u_dec (.op_code(op_code), .ctrl(ctrl));

  exec_operand #(.XLEN(XLEN), .IMMW(IMMW)) u_opnd (
    .bsel(ctrl.bsel), .base_zeroable(ctrl.base_zeroable), .base_zero(base_zero),
    .reg_a(opnd_a), .reg_b(opnd_b), .imm(imm16), .carry_in(carry_in),
    .src_a(src_a), .src_b(src_b)
  );

  exec_alu #(.XLEN(XLEN)) u_alu (.fn(ctrl.fn), .a(src_a), .b(src_b), .y(alu_y));

  assign cmp_x = ctrl.cmp_zero ? alu_y : src_a;
  assign cmp_y = ctrl.cmp_zero ? '0 : src_b;

  exec_cmp #(.XLEN(XLEN)) u_cmp (
    .signed_mode(ctrl.cmp_signed), .x(cmp_x), .y(cmp_y), .c(cmp_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result     <= '0;
      cond       <= '0;
      res_valid  <= 1'b0;
      cond_valid <= 1'b0;
      carry_clr  <= 1'b0;
      illegal    <= 1'b0;
    end else begin
      res_valid  <= 1'b0;
      cond_valid <= 1'b0;
      carry_clr  <= 1'b0;
      illegal    <= 1'b0;
      if (op_valid) begin
        if (!ctrl.legal) begin
          illegal <= 1'b1;
        end else begin
          if (ctrl.wr_res) begin
            result    <= alu_y;
            res_valid <= 1'b1;
          end
          if (ctrl.cmp_ops || ctrl.cmp_zero) begin
            cond       <= cmp_c;
            cond_valid <= 1'b1;
          end
          carry_clr <= ctrl.clr_carry;
        end
      end
    end
  end

  // R12: an illegal code disturbs neither register and raises no other pulse
  p_illegal_hold_r12: assert property (@(posedge clk) disable iff (rst)
    illegal |-> ($stable(result) && $stable(cond) && !res_valid && !cond_valid && !carry_clr));

  // R13: an idle cycle produces no pulse on the following cycle
  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!res_valid && !cond_valid && !illegal && !carry_clr));

  // R6: a compare alone leaves the result register untouched
  p_cmp_keeps_result_r6: assert property (@(posedge clk) disable iff (rst)
    (cond_valid && !res_valid) |-> $stable(result));

  // R5: a written condition field has exactly one of lt/gt/eq and a clear bit3
  p_cond_shape_r5: assert property (@(posedge clk) disable iff (rst)
    cond_valid |-> (!cond[3] && $countones(cond[2:0]) == 1));

  // R8: carry clearing only accompanies a register write
  p_carry_with_result_r8: assert property (@(posedge clk) disable iff (rst)
    carry_clr |-> res_valid);

  // R2: pulses last one cycle when the stage goes idle
  p_pulse_single_r2: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !op_valid) |=> !res_valid);

endmodule

// File: tb/test_int_exec_unit.sv
module test_int_exec_unit;
  import exec_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [5:0]  op_code = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [15:0] imm16 = '0;
  logic        base_zero = 1'b0, carry_in = 1'b0;
  logic [31:0] result;
  logic        res_valid, cond_valid, carry_clr, illegal;
  logic [3:0]  cond;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] m_res  = '0;
  logic [3:0]  m_cond = '0;
  bit done = 0;

  always #5 clk = ~clk;

  int_exec_unit i_int_exec_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm16(imm16), .base_zero(base_zero),
    .carry_in(carry_in), .result(result), .res_valid(res_valid), .cond(cond),
    .cond_valid(cond_valid), .carry_clr(carry_clr), .illegal(illegal)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] cmp_field(input logic [31:0] x, input logic [31:0] y,
                                           input bit sgn);
    bit lt, gt;
    if (sgn) begin
      lt = $signed(x) < $signed(y);
      gt = $signed(y) < $signed(x);
    end else begin
      lt = x < y;
      gt = y < x;
    end
    return {1'b0, x == y, gt, lt};
  endfunction

  function automatic string req_of(input logic [5:0] c);
    if (c >= 6'd32) return "R12";
    case (c)
      OP_ADD, OP_ADDI, OP_ADDIS: return "R3";
      OP_ADDZE: return "R9";
      OP_ANDR, OP_ANDIR, OP_ANDISR: return "R5";
      OP_MULLW, OP_MULLI: return "R11";
      OP_SLW, OP_SRW, OP_SRAW, OP_SRAWI: return "R7";
      OP_EXTSB, OP_EXTSH: return "R10";
      OP_SUBF, OP_SUBFIC: return "R8";
      OP_CMPW, OP_CMPWI, OP_CMPLW, OP_CMPLWI: return "R6";
      default: return "R4";
    endcase
  endfunction

  // One operation: drive at a falling edge, check at the next falling edge.
  task automatic run_op(input logic [5:0] c, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] im, input bit bz, input bit ci);
    logic [31:0] zi, hi, base, r;
    logic [3:0]  cf;
    bit wr, wc, cc, ill;
    int sh;
    zi = {16'h0, im};
    hi = {im, 16'h0};
    base = bz ? 32'h0 : a;
    wr = 1; wc = 0; cc = 0; ill = 0; r = 0; cf = 0;
    case (c)
      OP_ADD:    r = a + b;
      OP_ADDI:   r = base + zi;
      OP_ADDIS:  r = base + hi;
      OP_ADDZE:  r = a + (ci ? 32'd1 : 32'd0);
      OP_ANDR:   begin r = a & b;  wc = 1; end
      OP_ANDIR:  begin r = a & zi; wc = 1; end
      OP_ANDISR: begin r = a & hi; wc = 1; end
      OP_ANDC:   r = a & ~b;
      OP_OR:     r = a | b;
      OP_ORC:    r = a | ~b;
      OP_ORI:    r = a | zi;
      OP_ORIS:   r = a | hi;
      OP_XOR:    r = a ^ b;
      OP_XORI:   r = a ^ zi;
      OP_XORIS:  r = a ^ hi;
      OP_NAND:   r = ~(a & b);
      OP_NOR:    r = ~(a | b);
      OP_EQV:    r = ~(a ^ b);
      OP_MULLW:  r = 32'(64'(a) * 64'(b));
      OP_MULLI:  r = 32'(64'(a) * 64'(zi));
      OP_SLW:    begin sh = int'(b[5:0]); r = (sh > 31) ? 32'h0 : a << sh; end
      OP_SRW:    begin sh = int'(b[5:0]); r = (sh > 31) ? 32'h0 : a >> sh; end
      OP_SRAW, OP_SRAWI: begin
        sh = (c == OP_SRAW) ? int'(b[5:0]) : int'(im[5:0]);
        r = a;
        for (int k = 0; k < sh; k++) r = {a[31], r[31:1]};
        cc = 1;
      end
      OP_EXTSB:  r = {{24{a[7]}}, a[7:0]};
      OP_EXTSH:  r = {{16{a[15]}}, a[15:0]};
      OP_SUBF:   begin r = b - a;  cc = 1; end
      OP_SUBFIC: begin r = zi - a; cc = 1; end
      OP_CMPW:   begin wr = 0; wc = 1; cf = cmp_field(a, b, 1);  end
      OP_CMPWI:  begin wr = 0; wc = 1; cf = cmp_field(a, zi, 1); end
      OP_CMPLW:  begin wr = 0; wc = 1; cf = cmp_field(a, b, 0);  end
      OP_CMPLWI: begin wr = 0; wc = 1; cf = cmp_field(a, zi, 0); end
      default:   begin wr = 0; ill = 1; end
    endcase
    if (c == OP_ANDR || c == OP_ANDIR || c == OP_ANDISR) cf = cmp_field(r, 32'h0, 1);
    if (wr) m_res = r;
    if (wc) m_cond = cf;

    op_code = c; opnd_a = a; opnd_b = b; imm16 = im; base_zero = bz; carry_in = ci;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    check(req_of(c), "result", result, m_res);
    check(req_of(c), "cond", {28'h0, cond}, {28'h0, m_cond});
    check("R2", "res_valid", {31'h0, res_valid}, {31'h0, wr});
    check(req_of(c), "cond_valid", {31'h0, cond_valid}, {31'h0, wc});
    check("R8", "carry_clr", {31'h0, carry_clr}, {31'h0, cc});
    check("R12", "illegal", {31'h0, illegal}, {31'h0, ill});
  endtask

  task automatic idle_cycle();
    op_valid = 1'b0;
    op_code = 6'd63; opnd_a = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R13", "idle res_valid", {31'h0, res_valid}, 32'h0);
    check("R13", "idle illegal", {31'h0, illegal}, 32'h0);
    check("R13", "idle result", result, m_res);
    check("R13", "idle cond", {28'h0, cond}, {28'h0, m_cond});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "reset result", result, 32'h0);
    check("R1", "reset cond", {28'h0, cond}, 32'h0);
    check("R1", "reset pulses", {28'h0, res_valid, cond_valid, carry_clr, illegal}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "post-reset pulses", {28'h0, res_valid, cond_valid, carry_clr, illegal}, 32'h0);

    // R3: immediate forms and zeroed base
    run_op(OP_ADDI,  32'h1000_0000, 32'h0, 16'h8001, 1'b1, 1'b0);
    run_op(OP_ADDI,  32'h1000_0000, 32'h0, 16'h8001, 1'b0, 1'b0);
    run_op(OP_ADDIS, 32'h0000_0005, 32'h0, 16'h1234, 1'b1, 1'b0);
    run_op(OP_ADDIS, 32'h0000_0005, 32'h0, 16'h1234, 1'b0, 1'b0);
    run_op(OP_ORI,   32'h0000_0005, 32'h0, 16'h1234, 1'b1, 1'b0); // R4: base_zero ignored
    // R9: carry as 0/1
    run_op(OP_ADDZE, 32'hFFFF_FFFF, 32'h0, 16'h0, 1'b0, 1'b1);
    run_op(OP_ADDZE, 32'h0000_0007, 32'h0, 16'h0, 1'b0, 1'b0);
    // R6: signed vs unsigned at the sign boundary, equality
    run_op(OP_CMPW,  32'h8000_0000, 32'h1, 16'h0, 1'b0, 1'b0);
    run_op(OP_CMPLW, 32'h8000_0000, 32'h1, 16'h0, 1'b0, 1'b0);
    run_op(OP_CMPW,  32'h1234_5678, 32'h1234_5678, 16'h0, 1'b0, 1'b0);
    run_op(OP_CMPWI, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 1'b0, 1'b0);
    run_op(OP_CMPLWI, 32'h0000_FFFF, 32'h0, 16'hFFFF, 1'b0, 1'b0);
    // R5: record AND with zero, negative, positive results
    run_op(OP_ANDR,   32'hF0F0_F0F0, 32'h0F0F_0F0F, 16'h0, 1'b0, 1'b0);
    run_op(OP_ANDISR, 32'h8000_0001, 32'h0, 16'h8000, 1'b0, 1'b0);
    run_op(OP_ANDIR,  32'h8000_00FF, 32'h0, 16'h000F, 1'b0, 1'b0);
    // R7: shift amounts 31, 32, 63
    run_op(OP_SRAW, 32'h8000_0000, 32'd31, 16'h0, 1'b0, 1'b0);
    run_op(OP_SRAW, 32'h8000_0000, 32'd32, 16'h0, 1'b0, 1'b0);
    run_op(OP_SRAWI, 32'h8000_0000, 32'h0, 16'h003F, 1'b0, 1'b0);
    run_op(OP_SRW,  32'h8000_0000, 32'd63, 16'h0, 1'b0, 1'b0);
    run_op(OP_SLW,  32'h0000_0001, 32'hFFFF_FF1F, 16'h0, 1'b0, 1'b0);
    run_op(OP_SLW,  32'h0000_0001, 32'd32, 16'h0, 1'b0, 1'b0);
    // R8, R10, R11
    run_op(OP_SUBF,   32'd5, 32'd3, 16'h0, 1'b0, 1'b0);
    run_op(OP_SUBFIC, 32'd5, 32'h0, 16'hFFFF, 1'b0, 1'b0);
    run_op(OP_EXTSB,  32'h1234_5680, 32'h0, 16'h0, 1'b0, 1'b0);
    run_op(OP_EXTSH,  32'h1234_7FFF, 32'h0, 16'h0, 1'b0, 1'b0);
    run_op(OP_MULLW,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 1'b0, 1'b0);
    // R12: illegal codes hold state
    run_op(6'd32, 32'hDEAD_BEEF, 32'h1, 16'h1, 1'b0, 1'b1);
    run_op(6'd63, 32'h0, 32'h0, 16'h0, 1'b0, 1'b0);
    idle_cycle();

    for (int i = 0; i < 1500; i++) begin
      logic [5:0]  c;
      logic [31:0] a, b;
      c = (($urandom % 16) == 0) ? 6'(32 + ($urandom % 32)) : 6'($urandom % 32);
      a = $urandom;
      b = (($urandom % 4) == 0) ? ($urandom % 70) : $urandom;
      if (($urandom % 8) == 0) b = a;
      run_op(c, a, b, 16'($urandom), 1'($urandom), 1'($urandom));
      if (($urandom % 10) == 0) idle_cycle();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule